// File: doc/BRIEF.md
# Prioritised vectored interrupt controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and presents one interrupt level and one vector to the processor. Each source has an 8-bit control register. Bit 7 of that register selects autovectoring. Bits 4:2 hold the level and bits 1:0 hold a sub-priority. Bits 4:0, taken together as a 5-bit value, rank the sources against each other. A shared mask register blocks sources individually. A pending register, which software can read, mirrors the request inputs.

When a source wins and is not autovectored, the vector comes from one of three places. Source 8 (software watchdog) uses a programmable software vector register. Sources 12 and 13 (the two serial ports) use one programmable register each. Any other source falls back to a fixed vector. Sources 9 and 10 are intended for the two timers.

The level and vector are computed from the register state with combinational logic and are registered once per clock. A request input therefore reaches the outputs two clock edges after it changes. A register write reaches the outputs one edge after it has been stored. Software reaches the registers through a simple synchronous write port and a combinational read port.

Top module: `irq_prio_vec`

## Requirements
- R1: Pending register bit k (k = 1..13) equals request input k as sampled at the previous clock edge. Request input k is `req_i` bit k-1. Bit 0 of the pending register reads as 0.
- R2: A source whose mask bit k is 1 never wins. When no unmasked source is pending, `irq_level_o` and `irq_vec_o` are both 0.
- R3: Among the unmasked pending sources, the one with the largest control-register bits 4:0 wins.
- R4: When two winning candidates have equal bits 4:0, the lower-numbered source wins.
- R5: When the winning 5-bit value is below 4, both `irq_level_o` and `irq_vec_o` are 0.
- R6: `irq_level_o` equals bits 4:2 of the winner's control register.
- R7: When bit 7 of the winner's control register is 1, `irq_vec_o` equals 24 plus the level.
- R8: A winner that is not autovectored takes its vector from a register. Source 8 uses the software vector register (address 0x12). Source 12 uses serial vector 0 (address 0x13). Source 13 uses serial vector 1 (address 0x14).
- R9: Any other winner that is not autovectored gives vector 0x0F.
- R10: Reset values are as follows. Control registers 1..8 are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x1C. Registers 9..11 are 0x80 and registers 12..13 are 0x00. The mask is 0x3FFE. The software vector register is 0x0F.
- R11: Register map: control register k at address k (1..13), mask at 0x10 (bit k masks source k), pending at 0x11, and vector registers at 0x12 to 0x14. Writes take effect at the clock edge on which `reg_we_i` is high. The pending register is read-only, and writing to it has no effect. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 13 | Level request inputs; bit k-1 is source k |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_level_o | output | 3 | Registered interrupt level to the processor |
| irq_vec_o | output | 8 | Registered interrupt vector to the processor |

## Verification
The bench places two sources at an equal 5-bit value and checks that the lower number wins. A design using a greater-or-equal comparison would hand the interrupt to the higher source instead. It programs a source with a nonzero value below 4 and expects silence. A design that tests for "any active source" rather than the threshold would raise a level-0 interrupt with vector 0x0F. It masks the tie winner so that source 8 takes over, and checks that the software vector is used rather than the fallback, and that autovectoring yields 24 plus the level rather than a register value. It also writes to the pending register and checks that the register still tracks the inputs. A design that let the write through would report requests that do not exist.

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
  parameter int NSRC        = 13,
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int SWT_SRC     = 8,
  parameter int SER0_SRC    = 12,
  parameter int SER1_SRC    = 13,
  parameter int AUTO_BASE   = 24,
  parameter logic [7:0] FALLBACK_VEC = 8'h0F,
  parameter logic [AW-1:0] A_MASK = 5'h10,
  parameter logic [AW-1:0] A_PEND = 5'h11,
  parameter logic [AW-1:0] A_SWV  = 5'h12,
  parameter logic [AW-1:0] A_SV0  = 5'h13,
  parameter logic [AW-1:0] A_SV1  = 5'h14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [2:0]      irq_level_o,
  output logic [7:0]      irq_vec_o
);
  localparam int MW   = NSRC + 1;
  localparam int IDXW = $clog2(NSRC + 1);
  localparam logic [MW-1:0] MASK_RST = {{NSRC{1'b1}}, 1'b0};

  function automatic logic [7:0] ctl_rst(int k);
    if (k <= 7)       return 8'(4 * k);
    else if (k == 8)  return 8'h1C;
    else if (k <= 11) return 8'h80;
    else              return 8'h00;
  endfunction

  logic [7:0]    ctl_q [1:NSRC];
  logic [MW-1:0] mask_q, pend_q;
  logic [7:0]    swv_q, sv0_q, sv1_q;
  logic [2:0]    lvl_q;
  logic [7:0]    vec_q;
  logic          chk_ok_q;

  wire [MW-1:0] active = pend_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= NSRC; k++) ctl_q[k] <= ctl_rst(k);
      mask_q <= MASK_RST;
      pend_q <= '0;
      swv_q  <= 8'h0F;
      sv0_q  <= 8'h00;
      sv1_q  <= 8'h00;
    end else begin
      pend_q <= {req_i, 1'b0};
      if (reg_we_i) begin
        for (int k = 1; k <= NSRC; k++)
          if (reg_addr_i == AW'(k)) ctl_q[k] <= reg_wdata_i[7:0];
        if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i[MW-1:0];
        if (reg_addr_i == A_SWV)  swv_q  <= reg_wdata_i[7:0];
        if (reg_addr_i == A_SV0)  sv0_q  <= reg_wdata_i[7:0];
        if (reg_addr_i == A_SV1)  sv1_q  <= reg_wdata_i[7:0];
      end
    end
  end

  logic [4:0]      best_val;
  logic [IDXW-1:0] best_idx;
  logic [7:0]      win_ctl;

  always_comb begin
    best_val = '0;
    best_idx = '0;
    win_ctl  = '0;
    for (int k = 1; k <= NSRC; k++) begin
      if (active[k] && ctl_q[k][4:0] > best_val) begin
        best_val = ctl_q[k][4:0];
        best_idx = IDXW'(k);
        win_ctl  = ctl_q[k];
      end
    end
  end

  wire       hit      = best_val >= 5'd4;
  wire [2:0] lvl_next = hit ? win_ctl[4:2] : 3'd0;
  logic [7:0] vec_next;

  always_comb begin
    if (!hit)                            vec_next = 8'h00;
    else if (win_ctl[7])                 vec_next = 8'(AUTO_BASE) + {5'd0, lvl_next};
    else if (best_idx == IDXW'(SWT_SRC))  vec_next = swv_q;
    else if (best_idx == IDXW'(SER0_SRC)) vec_next = sv0_q;
    else if (best_idx == IDXW'(SER1_SRC)) vec_next = sv1_q;
    else                                 vec_next = FALLBACK_VEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      vec_q    <= '0;
      chk_ok_q <= 1'b0;
    end else begin
      lvl_q    <= lvl_next;
      vec_q    <= vec_next;
      chk_ok_q <= 1'b1;
    end
  end

  assign irq_level_o = lvl_q;
  assign irq_vec_o   = vec_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 1; k <= NSRC; k++)
      if (reg_addr_i == AW'(k)) reg_rdata_o = DW'(ctl_q[k]);
    if (reg_addr_i == A_MASK) reg_rdata_o = DW'(mask_q);
    if (reg_addr_i == A_PEND) reg_rdata_o = DW'(pend_q);
    if (reg_addr_i == A_SWV)  reg_rdata_o = DW'(swv_q);
    if (reg_addr_i == A_SV0)  reg_rdata_o = DW'(sv0_q);
    if (reg_addr_i == A_SV1)  reg_rdata_o = DW'(sv1_q);
  end

  AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok_q |-> pend_q == {$past(req_i), 1'b0}); // R1

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> (irq_level_o == 3'd0 && irq_vec_o == 8'h00)); // R2

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level_o == 3'd0) |-> (irq_vec_o == 8'h00)); // R5

  AST_LEVEL_FROM_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_level_o == $past(win_ctl[4:2])); // R6

  AST_PEND_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] == 1'b0); // R1
endmodule

// File: tb/irq_prio_vec_bench.sv
module irq_prio_vec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] req = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_vec u_irq_prio_vec (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_level_o(lvl), .irq_vec_o(vec)
  );

  task automatic chk(string req_tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    logic [7:0] exp;
    for (int k = 1; k <= 13; k++) begin
      exp = (k <= 7) ? 8'(4 * k) : (k == 8) ? 8'h1C : (k <= 11) ? 8'h80 : 8'h00;
      rd(5'(k), d);
      chk("R10 ctl reset", d, {8'h00, exp});
    end
    rd(5'h10, d); chk("R10 mask reset", d, 16'h3FFE);
    rd(5'h12, d); chk("R10 swvec reset", d, 16'h000F);
    chk("R10 level reset", {13'd0, lvl}, 16'd0);
    chk("R10 vector reset", {8'd0, vec}, 16'd0);
  endtask

  task automatic t_pending();
    logic [15:0] d;
    req = 13'h1A5C;
    settle();
    rd(5'h11, d); chk("R1 pending tracks inputs", d, {2'b00, 13'h1A5C, 1'b0});
    chk("R2 all masked level", {13'd0, lvl}, 16'd0);
    chk("R2 all masked vector", {8'd0, vec}, 16'd0);
    wr(5'h11, 16'hFFFF);
    rd(5'h11, d); chk("R11 pending write ignored", d, {2'b00, 13'h1A5C, 1'b0});
    rd(5'h1F, d); chk("R11 unmapped reads zero", d, 16'h0000);
    req = '0;
  endtask

  task automatic t_priority();
    wr(5'h10, 16'h0000);
    req = '0; req[2] = 1'b1; req[4] = 1'b1;
    settle();
    chk("R3 highest field wins level", {13'd0, lvl}, 16'd5);
    chk("R6/R9 fallback vector", {8'd0, vec}, 16'h000F);
    req = '0;
  endtask

  task automatic t_tie();
    req = '0; req[6] = 1'b1; req[7] = 1'b1;
    wr(5'h12, 16'h0040);
    settle();
    chk("R4 tie to source 7 level", {13'd0, lvl}, 16'd7);
    chk("R4 tie to source 7 vector", {8'd0, vec}, 16'h000F);
    wr(5'h10, 16'h0080);
    settle();
    chk("R2 mask moves win to 8", {13'd0, lvl}, 16'd7);
    chk("R8 software vector", {8'd0, vec}, 16'h0040);
    wr(5'h10, 16'h0000);
    req = '0;
  endtask

  task automatic t_lowfield();
    req = '0; req[4] = 1'b1; req[8] = 1'b1;
    wr(5'h05, 16'h0003);
    settle();
    chk("R5 below threshold level", {13'd0, lvl}, 16'd0);
    chk("R5 below threshold vector", {8'd0, vec}, 16'd0);
    req = '0;
  endtask

  task automatic t_autovec();
    logic [15:0] d;
    req = '0; req[8] = 1'b1;
    wr(5'h09, 16'h008C);
    rd(5'h09, d); chk("R11 ctl readback", d, 16'h008C);
    settle();
    chk("R6 autovector level", {13'd0, lvl}, 16'd3);
    chk("R7 autovector 24+level", {8'd0, vec}, 16'd27);
    req = '0;
  endtask

  task automatic t_serial();
    logic [15:0] d;
    wr(5'h0C, 16'h0010);
    wr(5'h0D, 16'h0018);
    wr(5'h13, 16'h0064);
    wr(5'h14, 16'h0065);
    rd(5'h13, d); chk("R11 serial vec0 readback", d, 16'h0064);
    req = '0; req[11] = 1'b1;
    settle();
    chk("R6 serial0 level", {13'd0, lvl}, 16'd4);
    chk("R8 serial0 vector", {8'd0, vec}, 16'h0064);
    req[12] = 1'b1;
    settle();
    chk("R3 serial1 outranks level", {13'd0, lvl}, 16'd6);
    chk("R8 serial1 vector", {8'd0, vec}, 16'h0065);
    req = '0;
    settle();
    chk("R2 idle after release", {13'd0, lvl}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending();
    t_priority();
    t_tie();
    t_lowfield();
    t_autovec();
    t_serial();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule